// File: doc/BRIEF.md
# Multichannel ADC Serial Frame Controller

This block is the host side of a serial link to a 16-channel, 12-bit successive-approximation converter. A start request opens a frame. The controller pulls the active-low chip select low and runs exactly 16 serial clock cycles. In those cycles it shifts a 16-bit control word out on DIN and clocks a 16-bit result word in from DOUT. The control word is built from the system-side channel, range, coding and sequence inputs. The serial clock speed comes from a divider input that is latched when the frame starts. The serial clock idles high. The converter takes DIN and launches DOUT on falling edges. The controller updates DIN and samples DOUT on rising edges.

The converter always answers with the conversion requested one frame earlier. For that reason the controller keeps the range and coding of the previous frame and the channel it asked for. The returned word carries a 4-bit channel tag in front of a 12-bit sample. The sample is widened to 16 bits in one of two ways, chosen by the coding bit the controller wrote in the previous frame: zero-extension for straight binary, sign-extension for two's complement. The result is shown for one cycle with a valid strobe. A flag is raised when the tag is not the channel that was requested.

The frame sequencer is a five-state machine:
- IDLE waits for a start request.
- LEAD holds chip select low for one half period before the first falling edge.
- LOW and HIGH are the two halves of each serial clock cycle.
- GAP keeps chip select high for the minimum time between frames.

The transitions are:
- IDLE→LEAD on a start request.
- LEAD→LOW, LOW→HIGH and HIGH→LOW when the half-period timer expires.
- HIGH→GAP on the expiry after the sixteenth rising edge.
- GAP→IDLE when the gap count is complete.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is held and right after it, chip select is high, the serial clock is high, DIN is 0 and the valid strobe is 0.
- R2: A start request seen in IDLE opens one frame. Chip select goes low and stays low for exactly 16 serial clock falling edges. A start request during a frame or its gap is ignored.
- R3: The control word goes out on DIN, most significant bit first. Bit 15 is 1 (write). Bits 14:13 are the sequence input, bits 12:9 the channel, bit 8 range, bit 7 coding, and bits 6:0 are 0. DIN changes only when the serial clock rises, so it is stable across every falling edge.
- R4: The serial clock is high whenever chip select is high. Each low phase lasts div_i system clock cycles, with div_i latched at start. A div_i of 0 acts as 1.
- R5: DOUT is sampled on each serial clock rising edge, and the first sample is bit 15 of the result word. Bits 15:12 are the channel tag and bits 11:0 the sample.
- R6: The valid strobe is high for exactly one cycle per frame. That cycle is the first cycle in which chip select is high again.
- R7: If the previous frame wrote coding 0, the 16-bit data output is the sample zero-extended. If it wrote coding 1, the sample is sign-extended from bit 11. Before any frame has ended, coding is taken as 0.
- R8: The range output with each result is the range bit written in the previous frame. Before any frame has ended, it is 0.
- R9: The mismatch flag rises together with the valid strobe only when a previous frame exists and the tag differs from the channel that frame requested. It is never raised on the first frame after reset.
- R10: Between two frames, chip select stays high for at least GAP_CYC system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Frame request |
| chan_i | input | 4 | Channel to request |
| range_i | input | 1 | Range bit to write |
| coding_i | input | 1 | Coding bit to write |
| seq_i | input | 2 | Sequence bits to write |
| div_i | input | DIV_W | Serial clock half period in system clocks |
| dout_i | input | 1 | Serial data from converter |
| sclk_o | output | 1 | Serial clock, idles high |
| cs_n_o | output | 1 | Active-low chip select |
| din_o | output | 1 | Serial data to converter |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_tag_o | output | 4 | Returned channel tag |
| res_data_o | output | 16 | Extended sample |
| res_range_o | output | 1 | Range bit for this result |
| tag_err_o | output | 1 | Tag mismatch flag |

## Verification
The bound checker watches the framing rules on every cycle:
- the serial clock stays parked high outside a frame;
- DIN holds steady through every low phase;
- the strobe is a single cycle that comes only with chip select high;
- the mismatch flag appears only with the strobe;
- chip select has been high for the minimum gap before it falls.

Only the bench scenarios can show the rest:
- the bit layout of the control word, the count of 16 falling edges and the measured half period, including the divider value 0;
- the split of the returned word and its zero- or sign-extension by the previous frame's coding;
- the one-frame lag of range and expected channel;
- that a start request raised during a busy frame gives no extra frame.

// File: rtl/adcf_pkg.sv
package adcf_pkg;
    localparam int FRAME_BITS = 16;
    localparam int TAG_W      = 4;
    localparam int SMP_W      = 12;
    localparam int OUT_W      = 16;
    localparam int SEQ_W      = 2;
    localparam int PAD_W      = FRAME_BITS - 1 - SEQ_W - TAG_W - 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_LOW,
        S_HIGH,
        S_GAP
    } fsm_state_t;
endpackage

// File: rtl/adcf_timer.sv
module adcf_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] half,
    output logic             expire
);
    logic [DIV_W-1:0] cnt_q;

    assign expire = !clr && (cnt_q == half - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/adcf_shreg.sv
module adcf_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic         sout,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    assign sout    = tx_q[W-1];
    assign rx_word = rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load) begin
            tx_q <= load_val;
        end else if (shift) begin
            tx_q <= {tx_q[W-2:0], 1'b0};
            rx_q <= {rx_q[W-2:0], sin};
        end
    end
endmodule

// File: rtl/adcf_decode.sv
module adcf_decode
    import adcf_pkg::*;
(
    input  logic [FRAME_BITS-1:0] word,
    input  logic                  twos,
    output logic [TAG_W-1:0]      tag,
    output logic [OUT_W-1:0]      data
);
    logic [SMP_W-1:0] smp;

    assign tag = word[FRAME_BITS-1 -: TAG_W];
    assign smp = word[SMP_W-1:0];

    always_comb begin
        if (twos) begin
            data = {{(OUT_W-SMP_W){smp[SMP_W-1]}}, smp};
        end else begin
            data = {{(OUT_W-SMP_W){1'b0}}, smp};
        end
    end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adcf_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int GAP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [3:0]       chan_i,
    input  logic             range_i,
    input  logic             coding_i,
    input  logic [1:0]       seq_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             dout_i,
    output logic             sclk_o,
    output logic             cs_n_o,
    output logic             din_o,
    output logic             res_valid_o,
    output logic [3:0]       res_tag_o,
    output logic [15:0]      res_data_o,
    output logic             res_range_o,
    output logic             tag_err_o
);
    localparam int BIT_W = $clog2(FRAME_BITS + 1);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    fsm_state_t st_q, st_nx;

    logic [DIV_W-1:0]      half_q;
    logic [BIT_W-1:0]      bit_q;
    logic [GAP_W-1:0]      gap_q;
    logic [TAG_W-1:0]      cur_chan_q, prev_chan_q;
    logic                  cur_rng_q, prev_rng_q;
    logic                  cur_cod_q, prev_cod_q;
    logic                  prev_ok_q;
    logic                  tick;
    logic                  last_bit;
    logic                  do_load;
    logic                  do_shift;
    logic [FRAME_BITS-1:0] ctl_word;
    logic [FRAME_BITS-1:0] rx_word;
    logic [TAG_W-1:0]      dec_tag;
    logic [OUT_W-1:0]      dec_data;

    assign ctl_word = {1'b1, seq_i, chan_i, range_i, coding_i, {PAD_W{1'b0}}};
    assign last_bit = (bit_q == BIT_W'(FRAME_BITS));
    assign do_load  = (st_q == S_IDLE) && start_i;
    assign do_shift = (st_q == S_LOW) && tick;

    adcf_timer #(.DIV_W(DIV_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (st_q == S_IDLE),
        .half   (half_q),
        .expire (tick)
    );

    adcf_shreg #(.W(FRAME_BITS)) u_shr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_load),
        .load_val (ctl_word),
        .shift    (do_shift),
        .sin      (dout_i),
        .sout     (din_o),
        .rx_word  (rx_word)
    );

    adcf_decode u_dec (
        .word (rx_word),
        .twos (prev_cod_q),
        .tag  (dec_tag),
        .data (dec_data)
    );

    // next-state logic
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            S_IDLE: if (start_i) st_nx = S_LEAD;
            S_LEAD: if (tick) st_nx = S_LOW;
            S_LOW:  if (tick) st_nx = S_HIGH;
            S_HIGH: if (tick) st_nx = last_bit ? S_GAP : S_LOW;
            S_GAP:  if (gap_q == GAP_W'(GAP_CYC - 1)) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // outputs and frame data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_o      <= 1'b1;
            cs_n_o      <= 1'b1;
            res_valid_o <= 1'b0;
            res_tag_o   <= '0;
            res_data_o  <= '0;
            res_range_o <= 1'b0;
            tag_err_o   <= 1'b0;
            half_q      <= DIV_W'(1);
            bit_q       <= '0;
            gap_q       <= '0;
            cur_chan_q  <= '0;
            cur_rng_q   <= 1'b0;
            cur_cod_q   <= 1'b0;
            prev_chan_q <= '0;
            prev_rng_q  <= 1'b0;
            prev_cod_q  <= 1'b0;
            prev_ok_q   <= 1'b0;
        end else begin
            res_valid_o <= 1'b0;
            tag_err_o   <= 1'b0;
            unique case (st_q)
                S_IDLE: begin
                    if (start_i) begin
                        cs_n_o     <= 1'b0;
                        half_q     <= (div_i == '0) ? DIV_W'(1) : div_i;
                        bit_q      <= '0;
                        cur_chan_q <= chan_i;
                        cur_rng_q  <= range_i;
                        cur_cod_q  <= coding_i;
                    end
                end
                S_LEAD: begin
                    if (tick) sclk_o <= 1'b0;
                end
                S_LOW: begin
                    if (tick) begin
                        sclk_o <= 1'b1;
                        bit_q  <= bit_q + BIT_W'(1);
                    end
                end
                S_HIGH: begin
                    if (tick) begin
                        if (last_bit) begin
                            cs_n_o      <= 1'b1;
                            res_valid_o <= 1'b1;
                            res_tag_o   <= dec_tag;
                            res_data_o  <= dec_data;
                            res_range_o <= prev_rng_q;
                            tag_err_o   <= prev_ok_q && (dec_tag != prev_chan_q);
                            prev_chan_q <= cur_chan_q;
                            prev_rng_q  <= cur_rng_q;
                            prev_cod_q  <= cur_cod_q;
                            prev_ok_q   <= 1'b1;
                            gap_q       <= '0;
                        end else begin
                            sclk_o <= 1'b0;
                        end
                    end
                end
                S_GAP: begin
                    gap_q <= gap_q + GAP_W'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/adcf_chk.sv
module adcf_chk #(
    parameter int GAP_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic din,
    input logic res_valid,
    input logic tag_err
);
    localparam int HW = $clog2(GAP_CYC + 2);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= HW'(GAP_CYC);
        end else if (!cs_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt < HW'(GAP_CYC)) begin
            hi_cnt <= hi_cnt + HW'(1);
        end
    end

    p_park_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    p_din_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !sclk && $past(!cs_n) && $past(!sclk)) |-> $stable(din));

    p_valid_cs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> cs_n);

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_err_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tag_err |-> res_valid);

    p_min_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= HW'(GAP_CYC)));
endmodule

bind adc_frame_ctrl adcf_chk #(.GAP_CYC(GAP_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n_o),
    .sclk      (sclk_o),
    .din       (din_o),
    .res_valid (res_valid_o),
    .tag_err   (tag_err_o)
);

// File: tb/sim_adc_frame_ctrl.sv
`timescale 1ns/1ps
module sim_adc_frame_ctrl;
    localparam int DIV_W = 8;
    localparam int GAP   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [3:0] chan_i = '0;
    logic range_i = 1'b0;
    logic coding_i = 1'b0;
    logic [1:0] seq_i = '0;
    logic [DIV_W-1:0] div_i = 8'd1;
    logic dout_i = 1'b0;
    logic sclk_o, cs_n_o, din_o, res_valid_o, res_range_o, tag_err_o;
    logic [3:0] res_tag_o;
    logic [15:0] res_data_o;

    always #10 clk = ~clk;

    adc_frame_ctrl #(.DIV_W(DIV_W), .GAP_CYC(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .range_i(range_i), .coding_i(coding_i), .seq_i(seq_i), .div_i(div_i),
        .dout_i(dout_i), .sclk_o(sclk_o), .cs_n_o(cs_n_o), .din_o(din_o),
        .res_valid_o(res_valid_o), .res_tag_o(res_tag_o), .res_data_o(res_data_o),
        .res_range_o(res_range_o), .tag_err_o(tag_err_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // converter model: takes DIN and launches DOUT on falling SCLK
    logic [15:0] resp = '0;
    logic [15:0] cap = '0;
    int k = 0;
    always @(negedge cs_n_o) begin
        k = 0;
        cap = '0;
    end
    always @(negedge sclk_o) begin
        if (!cs_n_o) begin
            cap = {cap[14:0], din_o};
            dout_i = (k < 16) ? resp[15-k] : 1'b0;
            k++;
        end
    end

    // monitors, sampled on the falling system clock edge
    int vcnt = 0;
    int vrun = 0;
    int vmax = 0;
    logic got_cs;
    logic [3:0] got_tag;
    logic [15:0] got_data;
    logic got_rng, got_err;
    int low_run = 0, low_min = 999, low_max = 0;
    int hi_run = 1000, last_gap = 1000, cs_falls = 0;
    logic p_sclk = 1'b1, p_cs = 1'b1;
    always @(negedge clk) begin
        if (res_valid_o) begin
            vcnt++;
            vrun++;
            got_cs = cs_n_o;
            got_tag = res_tag_o;
            got_data = res_data_o;
            got_rng = res_range_o;
            got_err = tag_err_o;
        end else begin
            vrun = 0;
        end
        if (vrun > vmax) vmax = vrun;
        if (!cs_n_o && !sclk_o) low_run++;
        if (sclk_o && !p_sclk) begin
            if (low_run < low_min) low_min = low_run;
            if (low_run > low_max) low_max = low_run;
            low_run = 0;
        end
        if (cs_n_o) hi_run++;
        if (!cs_n_o && p_cs) begin
            last_gap = hi_run;
            hi_run = 0;
            cs_falls++;
        end
        p_sclk = sclk_o;
        p_cs = cs_n_o;
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=finished", cyc);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // reference model of the previous frame
    logic [3:0] m_chan = '0;
    logic m_rng = 1'b0, m_cod = 1'b0, m_ok = 1'b0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ctl(input logic [3:0] c, input logic r, input logic cd, input logic [1:0] s);
        return {1'b1, s, c, r, cd, 7'b0};
    endfunction

    function automatic logic [15:0] ext(input logic [11:0] s, input logic twos);
        return twos ? {{4{s[11]}}, s} : {4'b0, s};
    endfunction

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_valid(input int v0);
        while (vcnt == v0) @(negedge clk);
        repeat (GAP + 3) @(negedge clk);
    endtask

    task automatic run_frame(input logic [3:0] c, input logic r, input logic cd, input logic [1:0] s,
                             input logic [7:0] dv, input logic [15:0] rw);
        int v0;
        int eh;
        v0 = vcnt;
        low_min = 999;
        low_max = 0;
        vmax = 0;
        eh = (dv == 0) ? 1 : int'(dv);
        @(negedge clk);
        chan_i = c; range_i = r; coding_i = cd; seq_i = s; div_i = dv; resp = rw;
        pulse_start();
        chan_i = ~c; range_i = ~r; coding_i = ~cd;
        wait_valid(v0);
        chk("R3", "control word", 32'(cap), 32'(ctl(c, r, cd, s)));
        chk("R2", "falling edges", 32'(k), 32'd16);
        chk("R4", "low phase min", 32'(low_min), 32'(eh));
        chk("R4", "low phase max", 32'(low_max), 32'(eh));
        chk("R6", "one strobe", 32'(vcnt - v0), 32'd1);
        chk("R6", "strobe width", 32'(vmax), 32'd1);
        chk("R6", "cs high at strobe", 32'(got_cs), 32'd1);
        chk("R5", "tag", 32'(got_tag), 32'(rw[15:12]));
        chk("R7", "data", 32'(got_data), 32'(ext(rw[11:0], m_cod)));
        chk("R8", "range", 32'(got_rng), 32'(m_rng));
        chk("R9", "mismatch", 32'(got_err), 32'(m_ok && (rw[15:12] != m_chan)));
        m_chan = c; m_rng = r; m_cod = cd; m_ok = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1", "cs_n", 32'(cs_n_o), 32'd1);
        chk("R1", "sclk", 32'(sclk_o), 32'd1);
        chk("R1", "din", 32'(din_o), 32'd0);
        chk("R1", "valid", 32'(res_valid_o), 32'd0);
    endtask

    task automatic t_first_frame();
        run_frame(4'h3, 1'b1, 1'b0, 2'b01, 8'd2, {4'h0, 12'hABC});
    endtask

    task automatic t_binary_lag();
        run_frame(4'h5, 1'b0, 1'b1, 2'b10, 8'd3, {4'h3, 12'h123});
    endtask

    task automatic t_twos_negative_div0();
        run_frame(4'h9, 1'b1, 1'b1, 2'b11, 8'd0, {4'h5, 12'h800});
    endtask

    task automatic t_twos_positive();
        run_frame(4'hC, 1'b0, 1'b0, 2'b00, 8'd1, {4'h9, 12'h7FF});
    endtask

    task automatic t_mismatch();
        run_frame(4'h2, 1'b1, 1'b0, 2'b01, 8'd2, {4'h4, 12'hFFF});
    endtask

    task automatic t_back_to_back();
        int v0;
        v0 = vcnt;
        @(negedge clk);
        chan_i = m_chan; range_i = 1'b0; coding_i = 1'b0; seq_i = 2'b00; div_i = 8'd1;
        resp = {m_chan, 12'h055};
        start_i = 1'b1;
        while (vcnt < v0 + 2) @(negedge clk);
        start_i = 1'b0;
        repeat (GAP + 3) @(negedge clk);
        chk("R10", "min gap", 32'(last_gap >= GAP), 32'd1);
        chk("R9", "no mismatch", 32'(got_err), 32'd0);
        chk("R7", "binary data", 32'(got_data), 32'h0055);
        m_rng = 1'b0; m_cod = 1'b0;
    endtask

    task automatic t_busy_start();
        int v0;
        int f0;
        v0 = vcnt;
        f0 = cs_falls;
        @(negedge clk);
        chan_i = m_chan; div_i = 8'd2; resp = {m_chan, 12'h001};
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();
        wait_valid(v0);
        repeat (40) @(negedge clk);
        chk("R2", "frames from busy start", 32'(cs_falls - f0), 32'd1);
        chk("R2", "results from busy start", 32'(vcnt - v0), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_frame();
        t_binary_lag();
        t_twos_negative_div0();
        t_twos_positive();
        t_mismatch();
        t_back_to_back();
        t_busy_start();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule